// File: doc/BRIEF.md
# UART Enhanced Feature Control Register Block

This block holds the enhanced-features control byte of a UART and guards the upper fields of three neighbouring control registers: the interrupt-enable, FIFO-control and modem-control registers. While its unlock bit is clear, those upper fields ignore host writes and keep their values. While the bit is set, they take writes like every other bit. The control byte also carries the CTS and RTS flow-control enables and a 4-bit software flow-control selector. These are brought out as plain outputs for the surrounding UART logic.

On the receive side, the block watches the received-byte stream. Every byte goes on to the receive FIFO one cycle later without change. When special-character detection is enabled and a byte equals the programmed match character, a sticky flag is raised for the interrupt-identification logic. The flag clears when the interrupt-identification register is read.

The host reaches all registers over a simple synchronous register bus. It has an address, write data, a write strobe, a read strobe and read data. The read data is combinational from the address.

Top module: `uart_xfeat_regs`

## Requirements
- R1: After reset, every register reads 0x00, the detection flag is 0 and all enable outputs are 0.
- R2: The control byte at address 3 maps bit 7 to the CTS flow enable, bit 6 to the RTS flow enable, bit 5 to the detection enable, bit 4 to the unlock bit and bits 3:0 to the software flow selector. A write is seen on the outputs and in read-back from the next cycle.
- R3: While the unlock bit is 0, host writes leave the protected fields unchanged. The protected fields are bits 7:4 of the interrupt-enable register (address 0), bits 5:4 of the FIFO-control register (address 1) and bits 7:5 of the modem-control register (address 2). The other bits of those registers are written.
- R4: While the unlock bit is 1, all 8 bits of addresses 0, 1 and 2 are written.
- R5: Clearing the unlock bit leaves the protected fields at their current values; it only freezes them.
- R6: The 8-bit match character register at address 4 resets to 0x00 and reads back what was written.
- R7: With detection enabled, a received byte equal to the match character sets the flag. The flag reads as bit 4 of the interrupt-identification register (address 5) from the cycle after the byte.
- R8: Every received byte appears on the FIFO-side outputs, unchanged, exactly one cycle after it arrives, whether or not it matches. The FIFO valid output is low when no byte arrived.
- R9: The flag holds through idle cycles until address 5 is read with the read strobe, and is 0 from the next cycle.
- R10: A match in the same cycle as a read of address 5 leaves the flag set.
- R11: With detection disabled, a matching byte does not set the flag.
- R12: Address 5 is read-only: a write to it changes nothing. Unmapped addresses (6, 7) read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe; a read of address 5 clears the flag |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| rx_valid | input | 1 | Received byte valid |
| rx_data | input | 8 | Received byte |
| rxq_valid | output | 1 | Byte valid toward the receive FIFO |
| rxq_data | output | 8 | Byte toward the receive FIFO |
| iir_spec_flag | output | 1 | Special-character flag for interrupt identification |
| ier_val | output | 8 | Interrupt-enable register contents |
| fcr_val | output | 8 | FIFO-control register contents |
| mcr_val | output | 8 | Modem-control register contents |
| cts_flow_en | output | 1 | CTS flow control enable |
| rts_flow_en | output | 1 | RTS flow control enable |
| swfc_sel | output | 4 | Software flow control selector |

## Verification
Register writes take effect one clock after the strobe, so the bench drives a write on a falling edge and checks read-back only from the following falling edge. Read data is combinational and is sampled 5 ns after the address is driven, before the rising edge that applies the flag clear. A received byte and its flag both appear one rising edge after the byte is driven; the bench checks the FIFO-side outputs at the next falling edge and reads the flag from there on. The case where a match and a read of address 5 coincide is driven in a single cycle, and the flag is then checked one cycle later.

// File: rtl/uart_xfeat_pkg.sv
package uart_xfeat_pkg;

    localparam int REG_W  = 8;
    localparam int ADDR_W = 3;
    localparam int N_PROT = 3;
    localparam int SWFC_W = 4;

    localparam logic [ADDR_W-1:0] ADDR_IER  = 3'd0;
    localparam logic [ADDR_W-1:0] ADDR_FCR  = 3'd1;
    localparam logic [ADDR_W-1:0] ADDR_MCR  = 3'd2;
    localparam logic [ADDR_W-1:0] ADDR_CTRL = 3'd3;
    localparam logic [ADDR_W-1:0] ADDR_CHAR = 3'd4;
    localparam logic [ADDR_W-1:0] ADDR_IIR  = 3'd5;

    localparam logic [REG_W-1:0] IER_LOCK = 8'hF0;
    localparam logic [REG_W-1:0] FCR_LOCK = 8'h30;
    localparam logic [REG_W-1:0] MCR_LOCK = 8'hE0;

    // index 0 = IER, 1 = FCR, 2 = MCR (index equals bus address)
    localparam logic [N_PROT-1:0][REG_W-1:0] LOCK_MASKS = {MCR_LOCK, FCR_LOCK, IER_LOCK};

    localparam int IIR_FLAG_BIT = 4;

    typedef struct packed {
        logic              cts_en;
        logic              rts_en;
        logic              det_en;
        logic              unlock;
        logic [SWFC_W-1:0] swfc;
    } xfeat_ctrl_t;

endpackage

// File: rtl/xfeat_regfile.sv
module xfeat_regfile
    import uart_xfeat_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [REG_W-1:0]  wr_data,
    output xfeat_ctrl_t       ctrl_o,
    output logic [REG_W-1:0]  char_o,
    output logic [REG_W-1:0]  ier_o,
    output logic [REG_W-1:0]  fcr_o,
    output logic [REG_W-1:0]  mcr_o
);

    typedef struct packed {
        xfeat_ctrl_t                     ctrl;
        logic [REG_W-1:0]                xchar;
        logic [N_PROT-1:0][REG_W-1:0]    prot;
    } regs_t;

    regs_t r_d, r_q;
    logic [N_PROT-1:0][REG_W-1:0] wmask;

    // per-register writable mask: protected field opens only when unlocked
    for (genvar g = 0; g < N_PROT; g++) begin : g_mask
        assign wmask[g] = r_q.ctrl.unlock ? {REG_W{1'b1}} : ~LOCK_MASKS[g];
    end

    always_comb begin
        r_d = r_q;
        if (wr_en) begin
            for (int i = 0; i < N_PROT; i++) begin
                if (wr_addr == ADDR_W'(i)) begin
                    r_d.prot[i] = (wr_data & wmask[i]) | (r_q.prot[i] & ~wmask[i]);
                end
            end
            if (wr_addr == ADDR_CTRL) r_d.ctrl  = xfeat_ctrl_t'(wr_data);
            if (wr_addr == ADDR_CHAR) r_d.xchar = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign ctrl_o = r_q.ctrl;
    assign char_o = r_q.xchar;
    assign ier_o  = r_q.prot[0];
    assign fcr_o  = r_q.prot[1];
    assign mcr_o  = r_q.prot[2];

    AST_LOCKED_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !ctrl_o.unlock) |=>
            ((ier_o & IER_LOCK) == ($past(ier_o) & IER_LOCK)) &&
            ((fcr_o & FCR_LOCK) == ($past(fcr_o) & FCR_LOCK)) &&
            ((mcr_o & MCR_LOCK) == ($past(mcr_o) & MCR_LOCK))); // R3

    AST_UNLOCKED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && ctrl_o.unlock && wr_addr == ADDR_IER) |=> ier_o == $past(wr_data)); // R4

    AST_RELOCK_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_CTRL) |=>
            (ier_o == $past(ier_o)) && (fcr_o == $past(fcr_o)) && (mcr_o == $past(mcr_o))); // R5

endmodule

// File: rtl/xfeat_spec_detect.sv
module xfeat_spec_detect
    import uart_xfeat_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             det_en,
    input  logic [REG_W-1:0] match_char,
    input  logic             rx_valid,
    input  logic [REG_W-1:0] rx_data,
    input  logic             iir_rd,
    output logic             fifo_valid,
    output logic [REG_W-1:0] fifo_data,
    output logic             flag
);

    typedef struct packed {
        logic             fv;
        logic [REG_W-1:0] fd;
        logic             flag;
    } det_t;

    det_t s_d, s_q;
    logic hit;

    always_comb begin
        hit  = det_en && rx_valid && (rx_data == match_char);
        s_d  = s_q;
        s_d.fv = rx_valid;
        if (rx_valid) s_d.fd = rx_data;
        if (hit)         s_d.flag = 1'b1;   // new match wins over clear
        else if (iir_rd) s_d.flag = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign fifo_valid = s_q.fv;
    assign fifo_data  = s_q.fd;
    assign flag       = s_q.flag;

    AST_FLAG_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (det_en && rx_valid && rx_data == match_char) |=> flag); // R7

    AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> (fifo_valid && fifo_data == $past(rx_data))); // R8

    AST_CLEAR_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (iir_rd && !(det_en && rx_valid && rx_data == match_char)) |=> !flag); // R9

    AST_IDLE_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        (!det_en && !flag) |=> !flag); // R11

endmodule

// File: rtl/uart_xfeat_regs.sv
module uart_xfeat_regs
    import uart_xfeat_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    input  logic              reg_wr,
    input  logic              reg_rd,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              rx_valid,
    input  logic [REG_W-1:0]  rx_data,
    output logic              rxq_valid,
    output logic [REG_W-1:0]  rxq_data,
    output logic              iir_spec_flag,
    output logic [REG_W-1:0]  ier_val,
    output logic [REG_W-1:0]  fcr_val,
    output logic [REG_W-1:0]  mcr_val,
    output logic              cts_flow_en,
    output logic              rts_flow_en,
    output logic [SWFC_W-1:0] swfc_sel
);

    xfeat_ctrl_t      ctrl;
    logic [REG_W-1:0] match_char;
    logic             iir_rd;
    logic [REG_W-1:0] iir_val;

    assign iir_rd = reg_rd && (reg_addr == ADDR_IIR);

    xfeat_regfile u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_wr),
        .wr_addr (reg_addr),
        .wr_data (reg_wdata),
        .ctrl_o  (ctrl),
        .char_o  (match_char),
        .ier_o   (ier_val),
        .fcr_o   (fcr_val),
        .mcr_o   (mcr_val)
    );

    xfeat_spec_detect u_det (
        .clk        (clk),
        .rst_n      (rst_n),
        .det_en     (ctrl.det_en),
        .match_char (match_char),
        .rx_valid   (rx_valid),
        .rx_data    (rx_data),
        .iir_rd     (iir_rd),
        .fifo_valid (rxq_valid),
        .fifo_data  (rxq_data),
        .flag       (iir_spec_flag)
    );

    always_comb begin
        iir_val = '0;
        iir_val[IIR_FLAG_BIT] = iir_spec_flag;
    end

    always_comb begin
        unique case (reg_addr)
            ADDR_IER:  reg_rdata = ier_val;
            ADDR_FCR:  reg_rdata = fcr_val;
            ADDR_MCR:  reg_rdata = mcr_val;
            ADDR_CTRL: reg_rdata = ctrl;
            ADDR_CHAR: reg_rdata = match_char;
            ADDR_IIR:  reg_rdata = iir_val;
            default:   reg_rdata = '0;
        endcase
    end

    assign cts_flow_en = ctrl.cts_en;
    assign rts_flow_en = ctrl.rts_en;
    assign swfc_sel    = ctrl.swfc;

    AST_MATCH_BEATS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (iir_rd && ctrl.det_en && rx_valid && rx_data == match_char) |=> iir_spec_flag); // R10

endmodule

// File: tb/uart_xfeat_regs_tb_top.sv
module uart_xfeat_regs_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic       reg_wr = 1'b0;
    logic       reg_rd = 1'b0;
    logic [7:0] reg_rdata;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_data = '0;
    logic       rxq_valid;
    logic [7:0] rxq_data;
    logic       iir_spec_flag;
    logic [7:0] ier_val, fcr_val, mcr_val;
    logic       cts_flow_en, rts_flow_en;
    logic [3:0] swfc_sel;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;  // 50 MHz

    uart_xfeat_regs dut_i (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
        .rx_valid(rx_valid), .rx_data(rx_data), .rxq_valid(rxq_valid),
        .rxq_data(rxq_data), .iir_spec_flag(iir_spec_flag), .ier_val(ier_val),
        .fcr_val(fcr_val), .mcr_val(mcr_val), .cts_flow_en(cts_flow_en),
        .rts_flow_en(rts_flow_en), .swfc_sel(swfc_sel)
    );

    // vector: {op[1:0], req[3:0], addr[2:0], data[7:0], exp[7:0]}
    localparam logic [1:0] OP_W = 2'd0, OP_R = 2'd1, OP_X = 2'd2;
    localparam int NV = 28;
    localparam logic [24:0] VEC [NV] = '{
        {OP_W, 4'd3,  3'd0, 8'hFF, 8'h00}, {OP_R, 4'd3,  3'd0, 8'h00, 8'h0F}, // R3 IER locked
        {OP_W, 4'd3,  3'd1, 8'hFF, 8'h00}, {OP_R, 4'd3,  3'd1, 8'h00, 8'hCF}, // R3 FCR locked
        {OP_W, 4'd3,  3'd2, 8'hFF, 8'h00}, {OP_R, 4'd3,  3'd2, 8'h00, 8'h1F}, // R3 MCR locked
        {OP_W, 4'd2,  3'd3, 8'h10, 8'h00}, {OP_R, 4'd2,  3'd3, 8'h00, 8'h10}, // R2 unlock
        {OP_W, 4'd4,  3'd0, 8'hA5, 8'h00}, {OP_R, 4'd4,  3'd0, 8'h00, 8'hA5}, // R4
        {OP_W, 4'd4,  3'd1, 8'h30, 8'h00}, {OP_R, 4'd4,  3'd1, 8'h00, 8'h30}, // R4
        {OP_W, 4'd4,  3'd2, 8'hE0, 8'h00}, {OP_R, 4'd4,  3'd2, 8'h00, 8'hE0}, // R4
        {OP_W, 4'd5,  3'd3, 8'h00, 8'h00}, {OP_R, 4'd5,  3'd0, 8'h00, 8'hA5}, // R5 relock keeps
        {OP_W, 4'd5,  3'd0, 8'h00, 8'h00}, {OP_R, 4'd5,  3'd0, 8'h00, 8'hA0}, // R5 frozen
        {OP_W, 4'd6,  3'd4, 8'h3C, 8'h00}, {OP_R, 4'd6,  3'd4, 8'h00, 8'h3C}, // R6
        {OP_W, 4'd7,  3'd3, 8'h20, 8'h00}, {OP_X, 4'd8,  3'd0, 8'h3C, 8'h3C}, // R7 enable, R8 match byte
        {OP_R, 4'd7,  3'd5, 8'h00, 8'h10}, {OP_R, 4'd9,  3'd5, 8'h00, 8'h00}, // R7 flag, R9 cleared
        {OP_X, 4'd8,  3'd0, 8'h11, 8'h11}, {OP_R, 4'd8,  3'd5, 8'h00, 8'h00}, // R8 non-match
        {OP_W, 4'd12, 3'd5, 8'hFF, 8'h00}, {OP_R, 4'd12, 3'd5, 8'h00, 8'h00}  // R12 IIR read-only
    };

    task automatic chk(input int req, input logic [7:0] act, input logic [7:0] exp, input string what);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL R%0d %s: actual=%02h expected=%02h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input int req, input logic [2:0] a, input logic [7:0] exp);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #5 chk(req, reg_rdata, exp, "read");
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic rx(input int req, input logic [7:0] d);
        @(negedge clk);
        rx_valid = 1'b1; rx_data = d;
        @(negedge clk);
        chk(req, {7'd0, rxq_valid}, 8'h01, "fifo valid");
        chk(req, rxq_data, d, "fifo data");
        rx_valid = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        bad++; total++;
        $display("FAIL R0 watchdog: actual=timeout expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        for (int a = 0; a < 8; a++) rd(1, 3'(a), 8'h00);
        chk(1, {cts_flow_en, rts_flow_en, 2'b00, swfc_sel}, 8'h00, "enables at reset");
        chk(1, {7'd0, iir_spec_flag}, 8'h00, "flag at reset");

        for (int i = 0; i < NV; i++) begin
            logic [24:0] v;
            v = VEC[i];
            case (v[24:23])
                OP_W: wr(v[18:16], v[15:8]);
                OP_R: rd(int'(v[22:19]), v[18:16], v[7:0]);
                default: rx(int'(v[22:19]), v[15:8]);
            endcase
        end

        // R2 field positions on ports
        wr(3'd3, 8'hCB);
        rd(2, 3'd3, 8'hCB);
        chk(2, {cts_flow_en, rts_flow_en, 2'b00, swfc_sel}, 8'hCB, "ctrl ports");
        chk(3, ier_val, 8'hA0, "ier port");

        // R9 flag holds through idle
        wr(3'd3, 8'h20);
        rx(7, 8'h3C);
        repeat (3) @(negedge clk);
        chk(9, {7'd0, iir_spec_flag}, 8'h01, "flag held");
        chk(8, {7'd0, rxq_valid}, 8'h00, "fifo idle");
        rd(9, 3'd5, 8'h10);
        rd(9, 3'd5, 8'h00);

        // R10 match together with IIR read
        rx(10, 8'h3C);
        @(negedge clk);
        rx_valid = 1'b1; rx_data = 8'h3C; reg_addr = 3'd5; reg_rd = 1'b1;
        #5 chk(10, reg_rdata, 8'h10, "read during match");
        @(negedge clk);
        rx_valid = 1'b0; reg_rd = 1'b0;
        rd(10, 3'd5, 8'h10);
        rd(10, 3'd5, 8'h00);

        // R11 detection disabled
        wr(3'd3, 8'h00);
        rx(11, 8'h3C);
        rd(11, 3'd5, 8'h00);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule